// File: doc/BRIEF.md
# Power Mode Direct Transfer Sequencer

This sequencer manages the jump from a low-power subclock operating mode straight into a running active mode, skipping the usual standby stop. When a sleep request arrives while the block sits idle in the subclock mode, it checks five mode-control inputs. If they all allow it, it picks either a high-speed or a medium-speed active mode as the target and starts timing the transfer. If any of them forbids it, it reports that ordinary standby or sleep handling applies instead.

The transfer has three timed stretches, and each one advances on a state tick supplied from outside. The tick comes at the subclock state rate before the switch and at the system-clock state rate after it. First come the states still on the old clock. Then the clock select flips and the target mode shows on the mode output. Next comes an oscillator-settling wait whose length is picked by a 3-bit field. Last come the interrupt-entry states, after which a one-cycle done pulse marks the end.

Top module: `pwr_direct_xfer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the block idle with `mode_o` = 2'b00 (subclock mode), `clk_sel_o` = 0 (subclock), and `done_o` and `fallback_o` low.
- R2: A transfer starts only when all of the following hold as `sleep_req` is seen: the block is idle, `mode_o` is 2'b00, `cfg_standby`=1, `cfg_lowspd_on`=0, `cfg_direct_en`=1 and `cfg_tick_src`=1. When the block is idle and `sleep_req` is seen without all of these, `fallback_o` goes high for exactly one cycle, no transfer starts, and state ticks then have no effect.
- R3: The target is high-speed (`mode_o` = 2'b01) when `cfg_medspd_on`=0, and medium-speed (`mode_o` = 2'b10) when `cfg_medspd_on`=1.
- R4: `clk_sel_o` rises to 1 and `mode_o` takes the target value in the cycle after the third accepted state tick of a transfer. Once risen, `clk_sel_o` stays at 1 until reset.
- R5: After the switch, the settling wait counts `settle_sel` values 0 through 7 as 8, 16, 32, 64, 128, 1024, 2048 and 8192 ticks.
- R6: After the settling wait, 14 more ticks are counted. `done_o` is high for exactly one cycle, in the cycle after tick number 3 + wait + 14, and the block then returns to idle.
- R7: `cfg_medspd_on` and `settle_sel` are captured when the transfer starts. Changes to them, or to the other control inputs, during a transfer do not change its target or timing. An active mode, once entered, holds until reset.
- R8: A `sleep_req` during a transfer is ignored. A `sleep_req` while idle in an active mode raises `fallback_o` and starts nothing.
- R9: `state_tick` has no effect while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Sleep request, one-cycle pulse |
| state_tick | input | 1 | One pulse per state of the current clock domain |
| cfg_standby | input | 1 | Standby selection bit |
| cfg_lowspd_on | input | 1 | Low-speed-on bit; must be 0 for a transfer |
| cfg_medspd_on | input | 1 | Selects medium-speed target when 1 |
| cfg_direct_en | input | 1 | Direct-transfer enable |
| cfg_tick_src | input | 1 | Timer clock-source select; must be 1 for a transfer |
| settle_sel | input | 3 | Oscillator-settling wait select |
| mode_o | output | 2 | 00 subclock mode, 01 high-speed, 10 medium-speed |
| clk_sel_o | output | 1 | 0 subclock, 1 system clock |
| done_o | output | 1 | One-cycle pulse when the transfer completes |
| fallback_o | output | 1 | One-cycle pulse when a sleep request takes the ordinary path |

## Verification
The assertions assume that `state_tick` is a single-cycle strobe, and that `sleep_req` is a pulse rather than a level that stays high across a whole transfer. The stimulus keeps to this by asserting each tick for one cycle, separated by random idle gaps. It also pulses `sleep_req` for single cycles only, including the random stray requests it injects in the middle of a transfer. The random control changes made during a transfer touch only inputs the block should ignore by then. The reference timing is computed in bench functions from the select field alone.

// File: rtl/pwr_direct_xfer.sv
module pwr_direct_xfer #(
  parameter int CNT_W      = 14,
  parameter int PRE_STATES = 3,
  parameter int IRQ_STATES = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  logic       state_tick,
  input  logic       cfg_standby,
  input  logic       cfg_lowspd_on,
  input  logic       cfg_medspd_on,
  input  logic       cfg_direct_en,
  input  logic       cfg_tick_src,
  input  logic [2:0] settle_sel,
  output logic [1:0] mode_o,
  output logic       clk_sel_o,
  output logic       done_o,
  output logic       fallback_o
);

  localparam logic [1:0] MODE_SUB = 2'b00;
  localparam logic [1:0] MODE_HI  = 2'b01;
  localparam logic [1:0] MODE_MED = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_SETTLE, ST_IRQ} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_last;
  logic             med_q;
  logic [2:0]       sel_q;
  logic             go;
  logic             at_last;

  function automatic logic [CNT_W-1:0] settle_last(input logic [2:0] s);
    case (s)
      3'd0:    return CNT_W'(8 - 1);
      3'd1:    return CNT_W'(16 - 1);
      3'd2:    return CNT_W'(32 - 1);
      3'd3:    return CNT_W'(64 - 1);
      3'd4:    return CNT_W'(128 - 1);
      3'd5:    return CNT_W'(1024 - 1);
      3'd6:    return CNT_W'(2048 - 1);
      default: return CNT_W'(8192 - 1);
    endcase
  endfunction

  assign go = (mode_o == MODE_SUB) && cfg_standby && !cfg_lowspd_on &&
              cfg_direct_en && cfg_tick_src;

  always_comb begin
    case (st)
      ST_PRE:    cnt_last = CNT_W'(PRE_STATES - 1);
      ST_SETTLE: cnt_last = settle_last(sel_q);
      default:   cnt_last = CNT_W'(IRQ_STATES - 1);
    endcase
  end

  assign at_last = (cnt == cnt_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      med_q      <= 1'b0;
      sel_q      <= 3'd0;
      mode_o     <= MODE_SUB;
      clk_sel_o  <= 1'b0;
      done_o     <= 1'b0;
      fallback_o <= 1'b0;
    end else begin
      done_o     <= 1'b0;
      fallback_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (sleep_req) begin
            if (go) begin
              st    <= ST_PRE;
              cnt   <= '0;
              med_q <= cfg_medspd_on;
              sel_q <= settle_sel;
            end else begin
              fallback_o <= 1'b1;
            end
          end
        end
        ST_PRE: begin
          if (state_tick) begin
            if (at_last) begin
              st        <= ST_SETTLE;
              cnt       <= '0;
              clk_sel_o <= 1'b1;
              mode_o    <= med_q ? MODE_MED : MODE_HI;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_SETTLE: begin
          if (state_tick) begin
            if (at_last) begin
              st  <= ST_IRQ;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (state_tick) begin
            if (at_last) begin
              st     <= ST_IDLE;
              cnt    <= '0;
              done_o <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/pwr_direct_xfer_chk.sv
module pwr_direct_xfer_chk (
  input logic       clk,
  input logic       rst,
  input logic       state_tick,
  input logic [1:0] mode_o,
  input logic       clk_sel_o,
  input logic       done_o,
  input logic       fallback_o
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R6
  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (rst) done_o |-> ($past(state_tick) && clk_sel_o)); // R6
  AST_FALLBACK_SINGLE: assert property (@(posedge clk) disable iff (rst) fallback_o |=> !fallback_o); // R2
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(done_o && fallback_o)); // R2
  AST_CLK_HELD: assert property (@(posedge clk) disable iff (rst) clk_sel_o |=> clk_sel_o); // R4
  AST_SWITCH_ON_TICK: assert property (@(posedge clk) disable iff (rst) $rose(clk_sel_o) |-> $past(state_tick)); // R4
  AST_ACTIVE_MODE: assert property (@(posedge clk) disable iff (rst) clk_sel_o |-> (mode_o == 2'b01 || mode_o == 2'b10)); // R3
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst) (mode_o != 2'b00) |=> $stable(mode_o)); // R7

endmodule

bind pwr_direct_xfer pwr_direct_xfer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .state_tick (state_tick),
  .mode_o     (mode_o),
  .clk_sel_o  (clk_sel_o),
  .done_o     (done_o),
  .fallback_o (fallback_o)
);

// File: tb/pwr_direct_xfer_bench.sv
module pwr_direct_xfer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_req = 1'b0;
  logic       state_tick = 1'b0;
  logic       cfg_standby = 1'b1;
  logic       cfg_lowspd_on = 1'b0;
  logic       cfg_medspd_on = 1'b0;
  logic       cfg_direct_en = 1'b1;
  logic       cfg_tick_src = 1'b1;
  logic [2:0] settle_sel = 3'd0;
  logic [1:0] mode_o;
  logic       clk_sel_o, done_o, fallback_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwr_direct_xfer u_pwr_direct_xfer (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .state_tick(state_tick),
    .cfg_standby(cfg_standby), .cfg_lowspd_on(cfg_lowspd_on),
    .cfg_medspd_on(cfg_medspd_on), .cfg_direct_en(cfg_direct_en),
    .cfg_tick_src(cfg_tick_src), .settle_sel(settle_sel),
    .mode_o(mode_o), .clk_sel_o(clk_sel_o), .done_o(done_o), .fallback_o(fallback_o)
  );

  function automatic int wait_of(input logic [2:0] s);
    case (s)
      3'd0: return 8;     3'd1: return 16;   3'd2: return 32;   3'd3: return 64;
      3'd4: return 128;   3'd5: return 1024; 3'd6: return 2048; default: return 8192;
    endcase
  endfunction

  function automatic logic [1:0] target_of(input logic med);
    return med ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic r);
    state_tick = t;
    sleep_req  = r;
    @(negedge clk);
    state_tick = 1'b0;
    sleep_req  = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(0, 0);
    cyc(0, 0);
    rst = 1'b0;
  endtask

  task automatic good_cfg();
    cfg_standby = 1'b1; cfg_lowspd_on = 1'b0; cfg_direct_en = 1'b1; cfg_tick_src = 1'b1;
  endtask

  task automatic run_xfer(input logic [2:0] sel, input logic med, input int maxgap, input bit disturb);
    int total;
    logic [1:0] exp_mode;
    good_cfg();
    settle_sel = sel;
    cfg_medspd_on = med;
    total = 3 + wait_of(sel) + 14;
    exp_mode = target_of(med);
    cyc(0, 1);
    chk(fallback_o == 1'b0, "R2 start no fallback", fallback_o, 0);
    chk(clk_sel_o == 1'b0 && mode_o == 2'b00, "R4 before ticks", clk_sel_o, 0);
    for (int i = 1; i <= total; i++) begin
      int gap = $urandom_range(0, maxgap);
      for (int g = 0; g < gap; g++) begin
        if (disturb) begin
          cfg_medspd_on = 1'($urandom);
          settle_sel    = 3'($urandom);
          cfg_direct_en = 1'($urandom);
        end
        cyc(0, disturb ? 1'($urandom_range(0, 3) == 0) : 1'b0);
        chk(done_o == 1'b0, "R8 no done in gap", done_o, 0);
      end
      cyc(1, 0);
      chk(clk_sel_o == (i >= 3), "R4 clock select", clk_sel_o, (i >= 3));
      chk(done_o == (i == total), "R6 done timing", done_o, (i == total));
      if (i >= 3) chk(mode_o == exp_mode, "R3 target mode", mode_o, exp_mode);
      else        chk(mode_o == 2'b00, "R4 mode before switch", mode_o, 0);
      if (i == 3 + wait_of(sel))
        chk(done_o == 1'b0, "R5 settle wait length", done_o, 0);
    end
    cyc(0, 0);
    chk(done_o == 1'b0, "R6 done one cycle", done_o, 0);
    chk(mode_o == exp_mode && clk_sel_o, "R7 mode held", mode_o, exp_mode);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk);
    do_reset();
    chk(mode_o == 2'b00, "R1 reset mode", mode_o, 0);
    chk(clk_sel_o == 1'b0, "R1 reset clk_sel", clk_sel_o, 0);
    chk(done_o == 1'b0 && fallback_o == 1'b0, "R1 reset pulses", done_o, 0);

    for (int k = 0; k < 20; k++) cyc(1, 0);
    chk(clk_sel_o == 1'b0 && mode_o == 2'b00 && done_o == 1'b0, "R9 idle ticks ignored", clk_sel_o, 0);

    for (int c = 0; c < 4; c++) begin
      good_cfg();
      case (c)
        0: cfg_standby   = 1'b0;
        1: cfg_lowspd_on = 1'b1;
        2: cfg_direct_en = 1'b0;
        default: cfg_tick_src = 1'b0;
      endcase
      cyc(0, 1);
      chk(fallback_o == 1'b1, "R2 fallback pulse", fallback_o, 1);
      cyc(0, 0);
      chk(fallback_o == 1'b0, "R2 fallback one cycle", fallback_o, 0);
      for (int k = 0; k < 25; k++) cyc(1, 0);
      chk(clk_sel_o == 1'b0 && mode_o == 2'b00 && done_o == 1'b0, "R2 no transfer", clk_sel_o, 0);
    end

    good_cfg();
    settle_sel = 3'd0;
    cfg_medspd_on = 1'b1;
    cyc(0, 1);
    for (int k = 0; k < 5; k++) cyc(1, 0);
    rst = 1'b1;
    cyc(0, 0);
    rst = 1'b0;
    chk(mode_o == 2'b00 && clk_sel_o == 1'b0, "R1 reset mid-transfer", mode_o, 0);

    for (int s = 0; s < 8; s++) begin
      do_reset();
      run_xfer(3'(s), 1'($urandom), (s >= 5) ? 1 : 3, 1'b1);
      good_cfg();
      cyc(0, 1);
      chk(fallback_o == 1'b1, "R8 request in active mode", fallback_o, 1);
      for (int k = 0; k < 30; k++) cyc(1, 0);
      chk(done_o == 1'b0 && clk_sel_o == 1'b1, "R8 no second transfer", done_o, 0);
    end

    do_reset();
    run_xfer(3'd2, 1'b0, 0, 1'b0);
    do_reset();
    run_xfer(3'd1, 1'b1, 0, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule